// File: doc/BRIEF.md
# Sample-Hold Phase Sequencer

This block is the digital controller of a low-power sample-and-hold output channel. It runs on a slow low-power clock. While enabled it waits for a trigger. It then powers the converter core and output buffer and drives the hold capacitor for a programmed sample time. Next it tri-states the output and switches the core and buffer off for a programmed hold time. After that it powers up again for a short refresh that tops up the held voltage. Hold and refresh then alternate until the next trigger, which starts a fresh sample phase.

The hold and refresh lengths are slow-domain inputs. The sample length is written from a fast bus clock. A two-flop toggle handshake moves the written value into the slow domain, and a busy flag in the bus domain stays high until the slow side has acknowledged the value. Software can therefore retune the sample time while the channel is running. Every phase length is counted in slow-clock cycles.

Top module: `shs_sequencer`

## Requirements
- R1: While `en_i` is low, the sequencer goes to idle (`phase_o` = 2'b00) on the next slow edge and holds `drive_en_o`, `core_pwr_o` and `buf_pwr_o` low. Triggers have no effect while it is disabled.
- R2: When enabled and idle, a trigger seen on a slow edge moves `phase_o` to sample (2'b01) on that edge, with all three control outputs high.
- R3: The sample phase lasts N+1 slow cycles, where N is the current 10-bit sample value.
- R4: Hold (`phase_o` = 2'b10) follows sample and lasts H slow cycles for a 10-bit hold value H; H = 0 counts as one cycle. During hold all three control outputs are low.
- R5: Refresh (`phase_o` = 2'b11) follows each hold and lasts F slow cycles for an 8-bit refresh value F; F = 0 counts as one cycle. During refresh all three control outputs are high. The phase after refresh is hold.
- R6: A trigger during the sample phase is ignored, and the phase runs its full length.
- R7: A trigger during hold or refresh ends that phase. A full-length sample phase begins on the same slow edge.
- R8: A bus write of the sample value raises `samp_busy_o` from the next bus edge. The flag clears once the slow domain has acknowledged the value through a two-flop synchronised toggle. The value applies from the next sample phase that starts after capture.
- R9: A bus write while `samp_busy_o` is high is ignored. The earlier value is the one that takes effect.
- R10: After reset, `phase_o` is idle, the control outputs are low, `samp_busy_o` is low, and the sample value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus_i | input | 1 | Fast bus clock |
| clk_lp_i | input | 1 | Slow low-power clock; every phase length is counted in its cycles |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| samp_we_i | input | 1 | Write strobe for the sample value (bus domain) |
| samp_wdata_i | input | 10 | New sample value N (bus domain) |
| samp_busy_o | output | 1 | A sample value is in transit to the slow domain (bus domain) |
| en_i | input | 1 | Mode enable (slow domain) |
| trig_i | input | 1 | Conversion trigger, sampled on each slow edge |
| hold_cyc_i | input | 10 | Hold length H in slow cycles |
| refr_cyc_i | input | 8 | Refresh length F in slow cycles |
| phase_o | output | 2 | Current phase: 00 idle, 01 sample, 10 hold, 11 refresh |
| drive_en_o | output | 1 | Output drive enable; low means tri-state |
| core_pwr_o | output | 1 | Converter core power enable |
| buf_pwr_o | output | 1 | Output buffer power enable |

## Verification
A new sample value can be captured in the slow domain on the same slow edge where a trigger loads the phase counter with the sample length. The bench provokes this collision by programming one value, then issuing a bus write of a second value at a bus-cycle offset that sweeps across the trigger's slow edge. For each offset, the measured sample phase must last either the old value plus one or the new value plus one, and never any other length. A later trigger must then show the new length.

// File: rtl/shs_pkg.sv
package shs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'b00,
    PH_SAMPLE  = 2'b01,
    PH_HOLD    = 2'b10,
    PH_REFRESH = 2'b11
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/shs_sync.sv
module shs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/shs_toggle_xfer.sv
module shs_toggle_xfer #(
  parameter int          W       = 10,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_bus_i,
  input  logic         clk_lp_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic [W-1:0] stage_o,
  output logic [W-1:0] val_o
);
  logic         req_q, ack_q, req_lp, ack_bus;
  logic [W-1:0] stage_q, val_q;

  // bus side: stage value and flip request while not busy
  shs_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk_i(clk_bus_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_bus)
  );

  assign busy_o = req_q ^ ack_bus;

  always_ff @(posedge clk_bus_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      stage_q <= RST_VAL;
    end else if (we_i && !busy_o) begin
      req_q   <= ~req_q;
      stage_q <= wdata_i;
    end
  end

  // slow side: staged data is stable while request differs from ack
  shs_sync #(.STAGES(STAGES)) u_req_sync (
    .clk_i(clk_lp_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_lp)
  );

  always_ff @(posedge clk_lp_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      val_q <= RST_VAL;
    end else if (req_lp != ack_q) begin
      ack_q <= req_lp;
      val_q <= stage_q;
    end
  end

  assign stage_o = stage_q;
  assign val_o   = val_q;
endmodule

// File: rtl/shs_phase_fsm.sv
module shs_phase_fsm
  import shs_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int HOLD_W = 10,
  parameter int REFR_W = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              trig_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic [REFR_W-1:0] refr_i,
  output phase_e            phase_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              drive_en_o,
  output logic              core_pwr_o,
  output logic              buf_pwr_o
);
  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] samp_ld, hold_ld, refr_ld;
  logic             cnt_zero, pwr_d;
  logic             drive_q, core_q, buf_q;

  // counters load length-1; zero length clamps to one cycle
  assign samp_ld  = CNT_W'(samp_i);
  assign hold_ld  = (hold_i == '0) ? '0 : CNT_W'(hold_i - HOLD_W'(1));
  assign refr_ld  = (refr_i == '0) ? '0 : CNT_W'(refr_i - REFR_W'(1));
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        PH_IDLE: if (trig_i) begin
          st_d  = PH_SAMPLE;
          cnt_d = samp_ld;
        end
        PH_SAMPLE: if (cnt_zero) begin
          st_d  = PH_HOLD;
          cnt_d = hold_ld;
        end else cnt_d = cnt_q - CNT_W'(1);
        PH_HOLD: if (trig_i) begin
          st_d  = PH_SAMPLE;
          cnt_d = samp_ld;
        end else if (cnt_zero) begin
          st_d  = PH_REFRESH;
          cnt_d = refr_ld;
        end else cnt_d = cnt_q - CNT_W'(1);
        PH_REFRESH: if (trig_i) begin
          st_d  = PH_SAMPLE;
          cnt_d = samp_ld;
        end else if (cnt_zero) begin
          st_d  = PH_HOLD;
          cnt_d = hold_ld;
        end else cnt_d = cnt_q - CNT_W'(1);
      endcase
    end
  end

  assign pwr_d = (st_d == PH_SAMPLE) || (st_d == PH_REFRESH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      drive_q <= 1'b0;
      core_q  <= 1'b0;
      buf_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      drive_q <= pwr_d;
      core_q  <= pwr_d;
      buf_q   <= pwr_d;
    end
  end

  assign phase_o    = st_q;
  assign cnt_o      = cnt_q;
  assign drive_en_o = drive_q;
  assign core_pwr_o = core_q;
  assign buf_pwr_o  = buf_q;
endmodule

// File: rtl/shs_sequencer.sv
module shs_sequencer
  import shs_pkg::*;
#(
  parameter int SAMP_W      = 10,
  parameter int HOLD_W      = 10,
  parameter int REFR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bus_i,
  input  logic              clk_lp_i,
  input  logic              rst_ni,
  input  logic              samp_we_i,
  input  logic [SAMP_W-1:0] samp_wdata_i,
  output logic              samp_busy_o,
  input  logic              en_i,
  input  logic              trig_i,
  input  logic [HOLD_W-1:0] hold_cyc_i,
  input  logic [REFR_W-1:0] refr_cyc_i,
  output logic [1:0]        phase_o,
  output logic              drive_en_o,
  output logic              core_pwr_o,
  output logic              buf_pwr_o
);
  localparam int CNT_W = max3(SAMP_W, HOLD_W, REFR_W);

  logic [SAMP_W-1:0] samp_lp, stage_data;
  logic [CNT_W-1:0]  fsm_cnt;
  phase_e            phase;

  shs_toggle_xfer #(
    .W(SAMP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)
  ) u_xfer (
    .clk_bus_i(clk_bus_i),
    .clk_lp_i (clk_lp_i),
    .rst_ni   (rst_ni),
    .we_i     (samp_we_i),
    .wdata_i  (samp_wdata_i),
    .busy_o   (samp_busy_o),
    .stage_o  (stage_data),
    .val_o    (samp_lp)
  );

  shs_phase_fsm #(
    .SAMP_W(SAMP_W), .HOLD_W(HOLD_W), .REFR_W(REFR_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i     (clk_lp_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .trig_i    (trig_i),
    .samp_i    (samp_lp),
    .hold_i    (hold_cyc_i),
    .refr_i    (refr_cyc_i),
    .phase_o   (phase),
    .cnt_o     (fsm_cnt),
    .drive_en_o(drive_en_o),
    .core_pwr_o(core_pwr_o),
    .buf_pwr_o (buf_pwr_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/shs_sequencer_chk.sv
module shs_sequencer_chk #(
  parameter int SAMP_W = 10
) (
  input logic              clk_lp_i,
  input logic              clk_bus_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              trig_i,
  input logic              samp_we_i,
  input logic              samp_busy_o,
  input logic [SAMP_W-1:0] stage_data_i,
  input logic              cnt_zero_i,
  input logic [1:0]        phase_o,
  input logic              drive_en_o,
  input logic              core_pwr_o,
  input logic              buf_pwr_o
);
  assert_idle_off_R1: assert property (@(posedge clk_lp_i) disable iff (!rst_ni)
    !en_i |=> (phase_o == 2'b00) && !drive_en_o && !core_pwr_o && !buf_pwr_o);

  assert_hold_quiet_R4: assert property (@(posedge clk_lp_i) disable iff (!rst_ni)
    (phase_o == 2'b10) |-> !drive_en_o && !core_pwr_o && !buf_pwr_o);

  assert_refresh_drive_R5: assert property (@(posedge clk_lp_i) disable iff (!rst_ni)
    (phase_o == 2'b11) |-> drive_en_o && core_pwr_o && buf_pwr_o);

  assert_no_retrig_R6: assert property (@(posedge clk_lp_i) disable iff (!rst_ni)
    en_i && (phase_o == 2'b01) && !cnt_zero_i |=> (phase_o == 2'b01));

  assert_retrig_R7: assert property (@(posedge clk_lp_i) disable iff (!rst_ni)
    en_i && trig_i && phase_o[1] |=> (phase_o == 2'b01));

  assert_busy_drop_R9: assert property (@(posedge clk_bus_i) disable iff (!rst_ni)
    samp_busy_o && samp_we_i |=> $stable(stage_data_i));
endmodule

bind shs_sequencer shs_sequencer_chk #(.SAMP_W(SAMP_W)) u_chk (
  .clk_lp_i    (clk_lp_i),
  .clk_bus_i   (clk_bus_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .trig_i      (trig_i),
  .samp_we_i   (samp_we_i),
  .samp_busy_o (samp_busy_o),
  .stage_data_i(stage_data),
  .cnt_zero_i  (fsm_cnt == '0),
  .phase_o     (phase_o),
  .drive_en_o  (drive_en_o),
  .core_pwr_o  (core_pwr_o),
  .buf_pwr_o   (buf_pwr_o)
);

// File: tb/shs_sequencer_tb_top.sv
module shs_sequencer_tb_top;
  logic       clk_bus = 1'b0, clk_lp = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0, en = 1'b0, trig = 1'b0;
  logic [9:0] wdata = '0, hold_cyc = '0;
  logic [7:0] refr_cyc = '0;
  logic       busy, drv, core, bufp;
  logic [1:0] phase;
  int         n_tests = 0, n_fail = 0;

  always #2.5 clk_bus = ~clk_bus;   // 200 MHz
  always #20  clk_lp  = ~clk_lp;

  shs_sequencer dut_i (
    .clk_bus_i(clk_bus), .clk_lp_i(clk_lp), .rst_ni(rst_n),
    .samp_we_i(we), .samp_wdata_i(wdata), .samp_busy_o(busy),
    .en_i(en), .trig_i(trig), .hold_cyc_i(hold_cyc), .refr_cyc_i(refr_cyc),
    .phase_o(phase), .drive_en_o(drv), .core_pwr_o(core), .buf_pwr_o(bufp)
  );

  typedef struct packed {logic [9:0] s; logic [9:0] h; logic [7:0] r;} vec_t;
  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{s: 10'd11,  h: 10'd62, r: 8'd4},
    '{s: 10'd0,   h: 10'd0,  r: 8'd0},
    '{s: 10'd3,   h: 10'd5,  r: 8'd1},
    '{s: 10'd6,   h: 10'd1,  r: 8'd255},
    '{s: 10'd1023,h: 10'd2,  r: 8'd2},
    '{s: 10'd2,   h: 10'd1023, r: 8'd7}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] v);
    @(negedge clk_bus); we = 1'b1; wdata = v;
    @(negedge clk_bus); we = 1'b0;
  endtask

  task automatic wait_busy(output int cyc);
    cyc = 0;
    while (busy && cyc < 400) begin @(negedge clk_bus); cyc++; end
  endtask

  task automatic prog_samp(input logic [9:0] v);
    int c;
    bus_write(v);
    wait_busy(c);
  endtask

  task automatic pulse_trig;
    @(negedge clk_lp); trig = 1'b1;
    @(negedge clk_lp); trig = 1'b0;
  endtask

  task automatic measure(input logic [1:0] ph, output int n);
    n = 0;
    while (phase == ph && n < 5000) begin n++; @(negedge clk_lp); end
  endtask

  function automatic int clamp1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n, c;
    #103 rst_n = 1'b1;
    @(negedge clk_lp);
    // R10 reset state
    chk("R10 phase", phase, 0);
    chk("R10 outputs", {drv, core, bufp}, 0);
    chk("R10 busy", busy, 0);

    // R1 trigger while disabled
    pulse_trig;
    chk("R1 trig ignored", phase, 0);
    chk("R1 outputs low", {drv, core, bufp}, 0);

    // R10 sample value resets to 0: one-cycle sample
    hold_cyc = 10'd3; refr_cyc = 8'd2;
    @(negedge clk_lp); en = 1'b1;
    pulse_trig;
    measure(2'b01, n);
    chk("R10 reset sample len", n, 1);

    // vector table: R2..R5
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_lp); en = 1'b0;
      @(negedge clk_lp);
      chk("R1 disable idles", phase, 0);
      prog_samp(VEC[i].s);
      @(negedge clk_lp);
      hold_cyc = VEC[i].h; refr_cyc = VEC[i].r; en = 1'b1;
      pulse_trig;
      chk("R2 sample entry", phase, 1);
      chk("R2 sample outputs", {drv, core, bufp}, 7);
      measure(2'b01, n);
      chk("R3 sample len", n, int'(VEC[i].s) + 1);
      chk("R4 hold entry", phase, 2);
      chk("R4 hold outputs", {drv, core, bufp}, 0);
      measure(2'b10, n);
      chk("R4 hold len", n, clamp1(int'(VEC[i].h)));
      chk("R5 refresh entry", phase, 3);
      chk("R5 refresh outputs", {drv, core, bufp}, 7);
      measure(2'b11, n);
      chk("R5 refresh len", n, clamp1(int'(VEC[i].r)));
      chk("R5 back to hold", phase, 2);
    end

    // R6 trigger inside sample ignored
    prog_samp(10'd9);
    @(negedge clk_lp); hold_cyc = 10'd20; refr_cyc = 8'd3;
    pulse_trig;
    n = 0;
    while (phase == 2'b01 && n < 100) begin
      n++; trig = (n == 3); @(negedge clk_lp);
    end
    trig = 1'b0;
    chk("R6 sample len kept", n, 10);

    // R7 trigger during hold
    repeat (5) @(negedge clk_lp);
    chk("R7 in hold", phase, 2);
    pulse_trig;
    chk("R7 hold retrigger", phase, 1);
    measure(2'b01, n);
    chk("R7 full sample after hold", n, 10);
    measure(2'b10, n);
    chk("R7 hold len", n, 20);
    @(negedge clk_lp);
    chk("R7 in refresh", phase, 3);
    pulse_trig;
    chk("R7 refresh retrigger", phase, 1);
    measure(2'b01, n);
    chk("R7 full sample after refresh", n, 10);

    // R8 / R9 busy handshake
    bus_write(10'd4);
    chk("R8 busy set", busy, 1);
    bus_write(10'd7);
    wait_busy(c);
    chk("R8 busy clears", (c < 400) ? 1 : 0, 1);
    pulse_trig;
    measure(2'b01, n);
    chk("R9 write while busy dropped", n, 5);

    // collision of capture and trigger: old or new length, then new
    for (int off = 0; off < 16; off++) begin
      int ns;
      prog_samp(10'd2);
      @(negedge clk_lp);
      fork
        begin pulse_trig; measure(2'b01, ns); end
        begin repeat (off) @(negedge clk_bus); bus_write(10'd6); end
      join
      chk("R8 collision len", (ns == 3 || ns == 7) ? 1 : 0, 1);
      if (ns != 3 && ns != 7) $display("  offset %0d len %0d", off, ns);
      wait_busy(c);
      pulse_trig;
      measure(2'b01, n);
      chk("R8 new value applied", n, 7);
    end

    // R1 disable mid hold
    @(negedge clk_lp);
    chk("R1 pre-disable hold", phase, 2);
    en = 1'b0;
    @(negedge clk_lp);
    chk("R1 idle after disable", phase, 0);
    chk("R1 outputs after disable", {drv, core, bufp}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule